// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Vectoring

The block gathers a set of interrupt request lines into pending bits. Each source has its own two-bit priority level. Every cycle the block picks one winner from the pending sources and registers it. It then presents the winner's source number, level and vector address to the instruction fetch logic. A two-bit mask field, held in the processor status register, is driven into the block. A source is only taken if its level is above that mask. The top level, 3, is taken no matter what the mask says.

When fetch accepts the interrupt it pulses an acknowledge strobe. That clears the winner's pending bit, and the next registered result shows whatever is still waiting. Vector addresses sit in two-word slots above a programmable base. Pin edge and level detection is done upstream. Context stacking and fetch are done downstream.

Top module: `irq_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following are all cleared: every pending bit, every source level, the vector base, `irq_valid_o`, `irq_src_o`, `irq_lvl_o` and `irq_vec_o`.
- R2: A source whose `req_i` bit is high at a clock edge becomes pending at that edge. An eligible pending source appears on the outputs at the next edge, so the result is registered one clock after the pending bit settles.
- R3: A pending source at level 3 is eligible for every mask value, and whenever one is eligible the registered winner has level 3.
- R4: A pending source at level 0, 1 or 2 is eligible only when its level is strictly greater than the unsigned 2-bit `mask_i` value; with `mask_i` = 3 only level-3 sources are taken.
- R5: Among eligible sources, the one with the highest level wins.
- R6: Among eligible sources that share the highest level, the lowest source index wins.
- R7: `irq_vec_o` equals the vector base plus two times `irq_src_o`, modulo 2^ADDR_W. The base is loaded from `base_d_i` at an edge where `base_we_i` is high.
- R8: When `ack_i` is high at an edge while `irq_valid_o` is high, the pending bit of source `irq_src_o` is cleared. The outputs registered at that same edge already leave that source out. An `ack_i` while `irq_valid_o` is low has no effect.
- R9: If the acknowledged source also has its `req_i` bit high at the acknowledge edge, it stays pending. It is offered again one clock later.
- R10: At an edge where `cfg_we_i` is high, the level of source `cfg_idx_i` is loaded from `cfg_lvl_i`. The new level governs arbitration from the next edge on.
- R11: A masked source keeps its pending bit, and it is taken once the mask drops below its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_SRC | Request strobes, one per source |
| cfg_we_i | input | 1 | Level write enable |
| cfg_idx_i | input | IDX_W | Source whose level is written |
| cfg_lvl_i | input | 2 | New level value |
| base_we_i | input | 1 | Vector base write enable |
| base_d_i | input | ADDR_W | New vector base |
| mask_i | input | 2 | Current priority mask from the status register |
| ack_i | input | 1 | Acknowledge strobe from fetch |
| irq_valid_o | output | 1 | A winner is presented |
| irq_src_o | output | IDX_W | Winning source index |
| irq_lvl_o | output | 2 | Winning source level |
| irq_vec_o | output | ADDR_W | Vector address of the winner |

## Verification
Several properties are checked on every cycle:
- any presented winner is still pending;
- a winner below level 3 clears the mask seen one edge earlier;
- an eligible level-3 request always yields a level-3 winner;
- the vector matches the base plus twice the source;
- an acknowledge without a simultaneous request removes the pending bit.

Other behaviours need the bench's scenarios: the lowest-index order among equal levels, level reprogramming, a request that coincides with its own acknowledge, an ignored acknowledge, and base wrap-around. In these scenarios a reference model predicts each registered result and compares it with the outputs.

// File: rtl/irq_arb_pkg.sv
// Shared types for the interrupt arbiter.
// Assumes exactly four priority levels encoded in two bits.
package irq_arb_pkg;
    localparam int LVL_W = 2;
    localparam int N_LVL = 1 << LVL_W;
    typedef logic [LVL_W-1:0] lvl_t;
    localparam lvl_t LVL_UNMASKABLE = 2'd3;
endpackage

// File: rtl/irq_pend_store.sv
// Per-source pending bits and priority level registers.
// Assumes req_i is an already-conditioned one-cycle or level strobe;
// a set in the same cycle as a clear keeps the bit pending.
module irq_pend_store
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       req_i,
    input  logic [N_SRC-1:0]       clr_i,
    input  logic                   cfg_we_i,
    input  logic [IDX_W-1:0]       cfg_idx_i,
    input  lvl_t                   cfg_lvl_i,
    output logic [N_SRC-1:0]       pend_o,
    output lvl_t [N_SRC-1:0]       lvl_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        // Pending bit: set by request, cleared by acknowledge of this source.
        always_ff @(posedge clk) begin
            if (!rst_n) pend_o[g] <= 1'b0;
            else        pend_o[g] <= (pend_o[g] & ~clr_i[g]) | req_i[g];
        end

        // Level register: loaded when the write addresses this source.
        always_ff @(posedge clk) begin
            if (!rst_n)                                     lvl_o[g] <= '0;
            else if (cfg_we_i && cfg_idx_i == IDX_W'(g))    lvl_o[g] <= cfg_lvl_i;
        end
    end
endmodule

// File: rtl/irq_pick.sv
// Combinational winner selection: mask gate, highest level, lowest index.
// Assumes clr_i marks a source being acknowledged this cycle, which is
// excluded so the registered result never repeats an accepted source.
module irq_pick
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = 8,
    parameter int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       pend_i,
    input  logic [N_SRC-1:0]       clr_i,
    input  lvl_t [N_SRC-1:0]       lvl_i,
    input  lvl_t                   mask_i,
    output logic                   hit_o,
    output logic [IDX_W-1:0]       idx_o,
    output lvl_t                   lvl_o
);
    logic [N_SRC-1:0]              elig;
    logic [N_LVL-1:0][N_SRC-1:0]   lvl_hit;
    logic [N_SRC-1:0]              row;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = pend_i[g] & ~clr_i[g] &
                         ((lvl_i[g] == LVL_UNMASKABLE) || (lvl_i[g] > mask_i));
        for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
            assign lvl_hit[l][g] = elig[g] && (lvl_i[g] == lvl_t'(l));
        end
    end

    // Highest occupied level, then lowest index within that level.
    always_comb begin
        lvl_o = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (|lvl_hit[l]) lvl_o = lvl_t'(l);
        end
        row   = lvl_hit[lvl_o];
        idx_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (row[i]) idx_o = IDX_W'(i);
        end
        hit_o = |elig;
    end
endmodule

// File: rtl/irq_vec_reg.sv
// Output register stage and vector base register.
// Vector = base + 2 * source index, wrapping at ADDR_W bits.
module irq_vec_reg
    import irq_arb_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int IDX_W  = $clog2(N_SRC),
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we_i,
    input  logic [ADDR_W-1:0] base_d_i,
    input  logic              hit_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  lvl_t              lvl_i,
    output logic              valid_o,
    output logic [IDX_W-1:0]  src_o,
    output lvl_t              lvl_o,
    output logic [ADDR_W-1:0] vec_o
);
    localparam int SLOT_SH = 1;

    logic [ADDR_W-1:0] base_q;

    // Base register holding the start of the vector table.
    always_ff @(posedge clk) begin
        if (!rst_n)         base_q <= '0;
        else if (base_we_i) base_q <= base_d_i;
    end

    // Register the arbitration result and its vector address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            src_o   <= '0;
            lvl_o   <= '0;
            vec_o   <= '0;
        end else begin
            valid_o <= hit_i;
            src_o   <= hit_i ? idx_i : '0;
            lvl_o   <= hit_i ? lvl_i : '0;
            vec_o   <= hit_i ? base_q + (ADDR_W'(idx_i) << SLOT_SH) : '0;
        end
    end

    // R7: presented vector sits in the two-word slot of the presented source.
    p_vec_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> vec_o == $past(base_q) + (ADDR_W'(src_o) << SLOT_SH));
endmodule

// File: rtl/irq_arbiter.sv
// Prioritised interrupt arbiter with vectoring (top level).
// Collects requests into pending bits, gates them by the status mask
// (level 3 bypasses it), picks highest level / lowest index, and
// registers source, level and vector. An acknowledge clears the winner.
module irq_arbiter
    import irq_arb_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int IDX_W  = $clog2(N_SRC),
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req_i,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic [1:0]        cfg_lvl_i,
    input  logic              base_we_i,
    input  logic [ADDR_W-1:0] base_d_i,
    input  logic [1:0]        mask_i,
    input  logic              ack_i,
    output logic              irq_valid_o,
    output logic [IDX_W-1:0]  irq_src_o,
    output logic [1:0]        irq_lvl_o,
    output logic [ADDR_W-1:0] irq_vec_o
);
    logic [N_SRC-1:0]  pend_w;
    logic [N_SRC-1:0]  clr_w;
    lvl_t [N_SRC-1:0]  lvl_w;
    logic              hit_w;
    logic [IDX_W-1:0]  idx_w;
    lvl_t              win_lvl_w;
    logic [N_SRC-1:0]  top_w;

    // Acknowledge decode: one-hot clear of the presented winner.
    always_comb begin
        clr_w = '0;
        if (ack_i && irq_valid_o) clr_w[irq_src_o] = 1'b1;
    end

    irq_pend_store #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .clr_i     (clr_w),
        .cfg_we_i  (cfg_we_i),
        .cfg_idx_i (cfg_idx_i),
        .cfg_lvl_i (cfg_lvl_i),
        .pend_o    (pend_w),
        .lvl_o     (lvl_w)
    );

    irq_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
        .pend_i (pend_w),
        .clr_i  (clr_w),
        .lvl_i  (lvl_w),
        .mask_i (mask_i),
        .hit_o  (hit_w),
        .idx_o  (idx_w),
        .lvl_o  (win_lvl_w)
    );

    irq_vec_reg #(.N_SRC(N_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we_i (base_we_i),
        .base_d_i  (base_d_i),
        .hit_i     (hit_w),
        .idx_i     (idx_w),
        .lvl_i     (win_lvl_w),
        .valid_o   (irq_valid_o),
        .src_o     (irq_src_o),
        .lvl_o     (irq_lvl_o),
        .vec_o     (irq_vec_o)
    );

    // Marks sources configured at the unmaskable level (assertion support).
    for (genvar g = 0; g < N_SRC; g++) begin : g_top
        assign top_w[g] = (lvl_w[g] == LVL_UNMASKABLE);
    end

    // R2: a presented winner is still pending.
    p_winner_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> pend_w[irq_src_o]);

    // R4: a maskable winner exceeded the mask in force when it was picked.
    p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_lvl_o != LVL_UNMASKABLE) |-> irq_lvl_o > $past(mask_i));

    // R3: an eligible level-3 request always produces a level-3 winner.
    p_unmaskable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_w & ~clr_w & top_w)) |=> (irq_valid_o && irq_lvl_o == LVL_UNMASKABLE));

    // R8: acknowledge without a coinciding request drops the pending bit.
    p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_valid_o && !req_i[irq_src_o]) |=> !pend_w[$past(irq_src_o)]);
endmodule

// File: tb/irq_arbiter_tb.sv
// Scoreboard bench: the driver predicts each registered result from a
// reference model and queues it; the monitor compares on falling edges.
module irq_arbiter_tb;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int AW = 16;

    typedef struct {
        logic          v;
        logic [IW-1:0] s;
        logic [1:0]    l;
        logic [AW-1:0] a;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [1:0]    cfg_lvl = '0;
    logic          base_we = 1'b0;
    logic [AW-1:0] base_d = '0;
    logic [1:0]    mask = '0;
    logic          ack = 1'b0;
    logic          irq_valid;
    logic [IW-1:0] irq_src;
    logic [1:0]    irq_lvl;
    logic [AW-1:0] irq_vec;

    int checks = 0;
    int errors = 0;
    exp_t q[$];

    // reference model state
    logic [N-1:0]  pend_m = '0;
    logic [1:0]    lvl_m[N];
    logic [AW-1:0] base_m = '0;
    logic          ov_m = 1'b0;
    logic [IW-1:0] os_m = '0;

    always #4 clk = ~clk;

    irq_arbiter #(.N_SRC(N), .IDX_W(IW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_lvl_i(cfg_lvl),
        .base_we_i(base_we), .base_d_i(base_d), .mask_i(mask), .ack_i(ack),
        .irq_valid_o(irq_valid), .irq_src_o(irq_src),
        .irq_lvl_o(irq_lvl), .irq_vec_o(irq_vec)
    );

    // One clock: drive, predict from the model, advance the model, queue.
    task automatic step(input logic [N-1:0] r, input logic a, input logic [1:0] m,
                        input logic we, input logic [IW-1:0] wi, input logic [1:0] wl,
                        input logic bwe, input logic [AW-1:0] bd, input string tag);
        exp_t e;
        logic [N-1:0] clr;
        logic found;
        @(negedge clk);
        req = r; ack = a; mask = m;
        cfg_we = we; cfg_idx = wi; cfg_lvl = wl;
        base_we = bwe; base_d = bd;
        clr = '0;
        if (a && ov_m) clr[os_m] = 1'b1;
        found = 1'b0;
        e.v = 1'b0; e.s = '0; e.l = '0; e.a = '0; e.tag = tag;
        for (int lv = 3; lv >= 0; lv--) begin
            for (int i = 0; i < N; i++) begin
                if (!found && pend_m[i] && !clr[i] && lvl_m[i] == 2'(lv) &&
                    (lv == 3 || 2'(lv) > m)) begin
                    found = 1'b1;
                    e.v = 1'b1; e.s = IW'(i); e.l = 2'(lv);
                    e.a = base_m + AW'(2 * i);
                end
            end
        end
        @(posedge clk);
        pend_m = (pend_m & ~clr) | r;
        if (we) lvl_m[wi] = wl;
        if (bwe) base_m = bd;
        ov_m = e.v; os_m = e.s;
        q.push_back(e);
    endtask

    task automatic tick(input logic [N-1:0] r, input logic a, input logic [1:0] m,
                        input string tag);
        step(r, a, m, 1'b0, '0, '0, 1'b0, '0, tag);
    endtask

    task automatic set_lvl(input int i, input logic [1:0] l);
        step('0, 1'b0, 2'd3, 1'b1, IW'(i), l, 1'b0, '0, "R10 level write");
    endtask

    task automatic set_base(input logic [AW-1:0] b);
        step('0, 1'b0, 2'd3, 1'b0, '0, '0, 1'b1, b, "R7 base write");
    endtask

    // Monitor: compare queued predictions with the outputs.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (irq_valid !== e.v || (e.v && (irq_src !== e.s || irq_lvl !== e.l ||
                irq_vec !== e.a))) begin
                errors++;
                $display("FAIL %s: got v=%0b s=%0d l=%0d a=%h exp v=%0b s=%0d l=%0d a=%h",
                         e.tag, irq_valid, irq_src, irq_lvl, irq_vec,
                         e.v, e.s, e.l, e.a);
            end
        end
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) lvl_m[i] = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (irq_valid !== 1'b0 || irq_src !== '0 || irq_lvl !== '0 || irq_vec !== '0) begin
            errors++;
            $display("FAIL R1: got v=%0b s=%0d l=%0d a=%h exp all zero",
                     irq_valid, irq_src, irq_lvl, irq_vec);
        end
        rst_n = 1'b1;
        tick('0, 1'b0, 2'd0, "R1 idle after reset");

        set_lvl(0, 2'd1); set_lvl(1, 2'd2); set_lvl(2, 2'd3); set_lvl(3, 2'd1);
        set_lvl(5, 2'd2); set_lvl(6, 2'd0); set_lvl(7, 2'd3);
        set_base(16'h0100);

        // R4: level 0 is never above mask 0
        tick(8'h40, 1'b0, 2'd0, "R4 level0 request");
        tick('0, 1'b0, 2'd0, "R4 level0 masked");
        // R2: latency and vector of a level-1 source
        tick(8'h08, 1'b0, 2'd0, "R2 request cycle");
        tick('0, 1'b0, 2'd0, "R2 winner src3");
        tick('0, 1'b1, 2'd0, "R8 ack clears src3");
        tick('0, 1'b0, 2'd0, "R8 nothing left");
        // R3 R5 R11: mixed levels under mask 2
        tick(8'h07, 1'b0, 2'd2, "R3 request burst");
        tick('0, 1'b0, 2'd2, "R3 level3 through mask2");
        tick('0, 1'b1, 2'd2, "R4 others masked after ack");
        tick('0, 1'b0, 2'd0, "R11 masked src1 taken, R5");
        tick('0, 1'b1, 2'd0, "R11 src0 next");
        tick('0, 1'b1, 2'd0, "R8 drain");
        tick('0, 1'b0, 2'd0, "R4 only level0 left");
        // R6: tie at level 3 under full mask
        tick(8'h84, 1'b0, 2'd3, "R6 tie request");
        tick('0, 1'b0, 2'd3, "R6 lowest index wins");
        tick('0, 1'b1, 2'd3, "R3 src7 after ack");
        tick('0, 1'b1, 2'd3, "R8 tie drained");
        // R9: request coinciding with its own acknowledge
        tick(8'h20, 1'b0, 2'd0, "R9 request src5");
        tick('0, 1'b0, 2'd0, "R9 src5 presented");
        tick(8'h20, 1'b1, 2'd0, "R9 ack with rerequest");
        tick('0, 1'b0, 2'd0, "R9 src5 again");
        tick('0, 1'b1, 2'd0, "R9 final ack");
        tick('0, 1'b0, 2'd0, "R9 idle");
        // R7: vector wraps past the top of the address range
        set_base(16'hFFFC);
        tick(8'h80, 1'b0, 2'd3, "R7 request src7");
        tick('0, 1'b0, 2'd3, "R7 wrapped vector");
        tick('0, 1'b1, 2'd3, "R7 ack");
        // R10: raise src6 to level 3, now taken under full mask
        set_lvl(6, 2'd3);
        tick('0, 1'b0, 2'd3, "R10 src6 now unmaskable");
        tick('0, 1'b1, 2'd3, "R10 ack src6");
        // R8: acknowledge with nothing presented is ignored
        tick(8'h01, 1'b0, 2'd3, "R8 masked src0 request");
        tick('0, 1'b1, 2'd3, "R8 stray ack");
        tick('0, 1'b1, 2'd3, "R8 stray ack again");
        tick('0, 1'b0, 2'd0, "R8 src0 survived stray ack");
        tick('0, 1'b1, 2'd0, "R8 ack src0");
        tick('0, 1'b0, 2'd0, "R8 empty");

        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule